// File: doc/BRIEF.md
# Three-Source Divided Clock Selector

This block drives a set of divided clock outputs. Each output picks one of three source clocks, divides it by a ratio kept in its own register, and can be switched off. Each source clock enters as a one-cycle strobe in the register clock domain, and every strobe marks one edge of that source. Each output is a registered level in the same domain, so the whole block runs on one clock.

Software writes a 2-bit select field for each output. Codes 0 to 2 pick a source and start the output. A separate off register is the only way to write code 3, which stops the output. Each output has one 5-bit divider register for each source, so changing the source also changes the ratio. Each source has a status register with one bit per output. That bit reports that the output is running from that source.

Each output is controlled by a small state machine with three states:
- OFF: the output is held low.
- RUN: the output toggles on the divider's terminal strobes.
- DRAIN: the old source is finished on its low phase.

The transitions are:
- OFF→RUN when the field holds a source code. The source is loaded and the count is cleared.
- RUN→OFF when the field differs from the active source and the output is low.
- RUN→DRAIN when the field differs from the active source and the output is high.
- DRAIN→OFF on the next terminal strobe of the old source, which drives the output low.

Top module: `cksel_top`

## Requirements
- R1: After reset every select field holds 3 (off), every divider holds 0, every output is low and every status bit is 0.
- R2: A write to a select register with field code 0, 1 or 2 stores that code and starts the output from that source. A field written as 3 through the select register is ignored and keeps its previous value.
- R3: Writing 1 to bit n of the off register (OFF_ADDR) sets field n to 3. The output then stops and stays low. The off register reads as 0.
- R4: With divider value v, the output toggles once every v+1 strobes of its selected source. Values 0..31 therefore give divide-by-1 to divide-by-32 of the source clock.
- R5: Each output n has a separate divider for each source s, at address DIV_BASE_s + 4·n, held in bits [4:0]. The divider that is applied is always the one of the active source.
- R6: The select field of output n starts at bit position p = SEL_BASE_BIT + 2·n of SEL_ADDR0. When p > 31, the field is at bit p − 32 of SEL_ADDR1.
- R7: Output changes are glitch-free:
  - An output changes only in the cycle after a strobe of its active source.
  - On a source change, a high output is first brought low by the old source.
  - The new source then starts low with a cleared count.
- R8: Bit STAT_BIT0 + n of status register STAT_BASE_s is 1 exactly when output n is running from source s and has made two edges (a rise and a fall) since it started. The bit clears as soon as the output stops running from that source.
- R9: Writes to status addresses have no effect.
- R10: A new divider value takes effect while the output runs. If the count is already at or above the new value, the next strobe ends the half-period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 3 | One strobe per source; each strobe is one source clock edge |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| ck_out | output | N_OUT | Divided, gated clock outputs |

## Verification
The three sources are driven at different strobe rates: every cycle, every second cycle and every third cycle. This makes the output period show whether the divider of the correct source was applied.

A switch from the slower source to a faster one is made while the output is high. This tests whether the old clock is finished on its low phase. A divider rewrite to a smaller value while the output is running tests the wrap rule.

Writes of code 3 through the select register and through the off register are compared, which separates the rejected path from the one that stops the output. An output whose field spills into the second select register tests the field layout.

// File: rtl/cksel_pkg.sv
package cksel_pkg;
    localparam int SRC_N = 3;
    localparam int DIV_W = 5;
    localparam logic [1:0] SEL_OFF = 2'd3;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_RUN   = 2'd1,
        CH_DRAIN = 2'd2
    } ch_state_t;
endpackage

// File: rtl/cksel_regs.sv
module cksel_regs import cksel_pkg::*; #(
    parameter int N_OUT = 14,
    parameter int AW = 12,
    parameter int SEL_BASE_BIT = 8,
    parameter logic [AW-1:0] SEL_ADDR0 = 12'h010,
    parameter logic [AW-1:0] SEL_ADDR1 = 12'h014,
    parameter logic [AW-1:0] OFF_ADDR = 12'h018,
    parameter logic [AW-1:0] STAT_BASE0 = 12'h020,
    parameter logic [AW-1:0] STAT_BASE1 = 12'h024,
    parameter logic [AW-1:0] STAT_BASE2 = 12'h028,
    parameter int STAT_BIT0 = 4,
    parameter logic [AW-1:0] DIV_BASE0 = 12'h100,
    parameter logic [AW-1:0] DIV_BASE1 = 12'h200,
    parameter logic [AW-1:0] DIV_BASE2 = 12'h300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [31:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0] rd_data,
    input  logic [N_OUT-1:0][SRC_N-1:0] run_n,
    output logic [N_OUT-1:0][1:0] sel_q,
    output logic [N_OUT-1:0][SRC_N-1:0][DIV_W-1:0] div_q
);
    function automatic logic [AW-1:0] sel_addr(input int n);
        return ((SEL_BASE_BIT + 2*n) > 31) ? SEL_ADDR1 : SEL_ADDR0;
    endfunction

    function automatic int sel_bit(input int n);
        return (SEL_BASE_BIT + 2*n) % 32;
    endfunction

    function automatic logic [AW-1:0] div_addr(input int s, input int n);
        logic [AW-1:0] base;
        base = (s == 0) ? DIV_BASE0 : (s == 1) ? DIV_BASE1 : DIV_BASE2;
        return base + AW'(4*n);
    endfunction

    function automatic logic [AW-1:0] stat_addr(input int s);
        return (s == 0) ? STAT_BASE0 : (s == 1) ? STAT_BASE1 : STAT_BASE2;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= {N_OUT{SEL_OFF}};
            div_q <= '0;
        end else if (wr_en) begin
            for (int n = 0; n < N_OUT; n++) begin
                if (wr_addr == sel_addr(n) && wr_data[sel_bit(n) +: 2] != SEL_OFF)
                    sel_q[n] <= wr_data[sel_bit(n) +: 2];
                if (wr_addr == OFF_ADDR && wr_data[n])
                    sel_q[n] <= SEL_OFF;
                for (int s = 0; s < SRC_N; s++)
                    if (wr_addr == div_addr(s, n))
                        div_q[n][s] <= wr_data[DIV_W-1:0];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int n = 0; n < N_OUT; n++) begin
            if (rd_addr == sel_addr(n))
                rd_data = rd_data | (32'(sel_q[n]) << sel_bit(n));
            for (int s = 0; s < SRC_N; s++) begin
                if (rd_addr == div_addr(s, n))
                    rd_data = rd_data | 32'(div_q[n][s]);
                if (rd_addr == stat_addr(s))
                    rd_data = rd_data | (32'(run_n[n][s]) << (STAT_BIT0 + n));
            end
        end
    end
endmodule

// File: rtl/cksel_chan.sv
module cksel_chan import cksel_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic [SRC_N-1:0] tick,
    input  logic [1:0] fld,
    input  logic [SRC_N-1:0][DIV_W-1:0] div_all,
    output logic ck,
    output logic [SRC_N-1:0] run
);
    ch_state_t st_q, st_d;
    logic [1:0] act_q, act_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [1:0] edg_q, edg_d;
    logic ck_q, ck_d;
    logic tk;
    logic [DIV_W-1:0] dv;

    always_comb begin
        tk = (act_q == 2'd2) ? tick[2] : (act_q == 2'd1) ? tick[1] : tick[0];
        dv = (act_q == 2'd2) ? div_all[2] : (act_q == 2'd1) ? div_all[1] : div_all[0];
    end

    always_comb begin
        st_d = st_q;
        act_d = act_q;
        cnt_d = cnt_q;
        edg_d = edg_q;
        ck_d = ck_q;
        unique case (st_q)
            CH_OFF: begin
                ck_d = 1'b0;
                if (fld != SEL_OFF) begin
                    act_d = fld;
                    cnt_d = '0;
                    edg_d = '0;
                    st_d = CH_RUN;
                end
            end
            CH_RUN: begin
                if (fld != act_q) begin
                    st_d = ck_q ? CH_DRAIN : CH_OFF;
                end else if (tk) begin
                    if (cnt_q >= dv) begin
                        cnt_d = '0;
                        ck_d = ~ck_q;
                        if (edg_q != 2'd2) edg_d = edg_q + 2'd1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            CH_DRAIN: begin
                if (tk) begin
                    if (cnt_q >= dv) begin
                        cnt_d = '0;
                        ck_d = 1'b0;
                        st_d = CH_OFF;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: st_d = CH_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CH_OFF;
            act_q <= '0;
            cnt_q <= '0;
            edg_q <= '0;
            ck_q <= 1'b0;
        end else begin
            st_q <= st_d;
            act_q <= act_d;
            cnt_q <= cnt_d;
            edg_q <= edg_d;
            ck_q <= ck_d;
        end
    end

    assign ck = ck_q;

    for (genvar s = 0; s < SRC_N; s++) begin : g_run
        assign run[s] = (st_q == CH_RUN) && (act_q == 2'(s)) && (edg_q == 2'd2);
    end
endmodule

// File: rtl/cksel_top.sv
module cksel_top import cksel_pkg::*; #(
    parameter int N_OUT = 14,
    parameter int AW = 12,
    parameter int SEL_BASE_BIT = 8,
    parameter logic [AW-1:0] SEL_ADDR0 = 12'h010,
    parameter logic [AW-1:0] SEL_ADDR1 = 12'h014,
    parameter logic [AW-1:0] OFF_ADDR = 12'h018,
    parameter logic [AW-1:0] STAT_BASE0 = 12'h020,
    parameter logic [AW-1:0] STAT_BASE1 = 12'h024,
    parameter logic [AW-1:0] STAT_BASE2 = 12'h028,
    parameter int STAT_BIT0 = 4,
    parameter logic [AW-1:0] DIV_BASE0 = 12'h100,
    parameter logic [AW-1:0] DIV_BASE1 = 12'h200,
    parameter logic [AW-1:0] DIV_BASE2 = 12'h300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic [2:0] src_tick,
    input  logic wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [31:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0] rd_data,
    output logic [N_OUT-1:0] ck_out
);
    logic [N_OUT-1:0][1:0] sel_q;
    logic [N_OUT-1:0][SRC_N-1:0][DIV_W-1:0] div_q;
    logic [N_OUT-1:0][SRC_N-1:0] run_n;

    cksel_regs #(
        .N_OUT(N_OUT), .AW(AW), .SEL_BASE_BIT(SEL_BASE_BIT),
        .SEL_ADDR0(SEL_ADDR0), .SEL_ADDR1(SEL_ADDR1), .OFF_ADDR(OFF_ADDR),
        .STAT_BASE0(STAT_BASE0), .STAT_BASE1(STAT_BASE1), .STAT_BASE2(STAT_BASE2),
        .STAT_BIT0(STAT_BIT0),
        .DIV_BASE0(DIV_BASE0), .DIV_BASE1(DIV_BASE1), .DIV_BASE2(DIV_BASE2)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .run_n(run_n), .sel_q(sel_q), .div_q(div_q)
    );

    for (genvar n = 0; n < N_OUT; n++) begin : g_ch
        cksel_chan u_chan (
            .clk(clk), .rst_n(rst_n), .tick(src_tick), .fld(sel_q[n]),
            .div_all(div_q[n]), .ck(ck_out[n]), .run(run_n[n])
        );
    end
endmodule

// File: rtl/cksel_chk.sv
module cksel_chk #(
    parameter int N_OUT = 14,
    parameter int AW = 12,
    parameter logic [AW-1:0] OFF_ADDR = 12'h018
) (
    input logic clk,
    input logic rst_n,
    input logic [2:0] src_tick,
    input logic [N_OUT-1:0] ck_out,
    input logic wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [31:0] wr_data,
    input logic [N_OUT-1:0][1:0] sel_q,
    input logic [N_OUT-1:0][2:0] run_n
);
    for (genvar n = 0; n < N_OUT; n++) begin : g_a
        // R7: an output moves only after a source strobe
        assert_edge_after_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (ck_out[n] != $past(ck_out[n])) |-> $past(|src_tick));
        // R8: an output reports running from at most one source
        assert_one_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(run_n[n]) <= 1);
        // R8: running is first reported on the falling second edge
        assert_run_on_second_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(|run_n[n]) |-> $fell(ck_out[n]));
        // R3: the off register forces the field to code 3
        assert_off_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == OFF_ADDR && wr_data[n]) |=> (sel_q[n] == 2'b11));
    end
endmodule

bind cksel_top cksel_chk #(.N_OUT(N_OUT), .AW(AW), .OFF_ADDR(OFF_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .ck_out(ck_out),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sel_q(sel_q), .run_n(run_n)
);

// File: tb/test_cksel_top.sv
module test_cksel_top;
    localparam int N = 14;
    localparam int BASEB = 8;
    localparam logic [11:0] SEL0 = 12'h010, SEL1 = 12'h014, OFFA = 12'h018;
    localparam logic [11:0] ST0 = 12'h020, ST1 = 12'h024, ST2 = 12'h028;
    localparam int SB0 = 4;
    localparam int DB[3] = '{32'h100, 32'h200, 32'h300};

    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] src_tick = 3'b0;
    logic wr_en = 1'b0;
    logic [11:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [N-1:0] ck_out;

    int checks = 0, errors = 0, cyc = 0;
    int per[3] = '{2, 3, 1};
    bit finished = 0;

    cksel_top i_cksel_top (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .ck_out(ck_out)
    );

    always #10 clk = ~clk;

    // reference model: state 0 off, 1 running, 2 finishing old source
    int m_fld[N], m_st[N], m_act[N], m_cnt[N], m_ck[N], m_edg[N];
    int m_div[3][N];

    initial for (int n = 0; n < N; n++) begin
        m_fld[n] = 3; m_st[n] = 0; m_act[n] = 0; m_cnt[n] = 0; m_ck[n] = 0; m_edg[n] = 0;
        for (int s = 0; s < 3; s++) m_div[s][n] = 0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < N; n++) begin
                m_fld[n] = 3; m_st[n] = 0; m_act[n] = 0; m_cnt[n] = 0; m_ck[n] = 0; m_edg[n] = 0;
                for (int s = 0; s < 3; s++) m_div[s][n] = 0;
            end
        end else begin
            for (int n = 0; n < N; n++) begin
                logic t;
                int lim;
                t = src_tick[m_act[n]];
                lim = m_div[m_act[n]][n];
                if (m_st[n] == 0) begin
                    if (m_fld[n] != 3) begin
                        m_act[n] = m_fld[n]; m_cnt[n] = 0; m_edg[n] = 0; m_st[n] = 1;
                    end
                end else if (m_st[n] == 1) begin
                    if (m_fld[n] != m_act[n]) m_st[n] = (m_ck[n] != 0) ? 2 : 0;
                    else if (t) begin
                        if (m_cnt[n] >= lim) begin
                            m_cnt[n] = 0; m_ck[n] = 1 - m_ck[n];
                            if (m_edg[n] < 2) m_edg[n]++;
                        end else m_cnt[n]++;
                    end
                end else if (t) begin
                    if (m_cnt[n] >= lim) begin m_cnt[n] = 0; m_ck[n] = 0; m_st[n] = 0; end
                    else m_cnt[n]++;
                end
            end
            if (wr_en) begin
                for (int n = 0; n < N; n++) begin
                    int p, b, v;
                    p = BASEB + 2*n; b = p % 32;
                    v = int'((wr_data >> b) & 32'd3);
                    if (wr_addr == ((p > 31) ? SEL1 : SEL0) && v != 3) m_fld[n] = v;
                    if (wr_addr == OFFA && wr_data[n]) m_fld[n] = 3;
                    for (int s = 0; s < 3; s++)
                        if (int'(wr_addr) == DB[s] + 4*n) m_div[s][n] = int'(wr_data & 32'h1f);
                end
            end
        end
    end

    function automatic logic [N-1:0] m_outs();
        logic [N-1:0] o;
        for (int n = 0; n < N; n++) o[n] = (m_ck[n] != 0);
        return o;
    endfunction

    // source strobes, driven away from the active edge
    always @(negedge clk) begin
        cyc++;
        for (int s = 0; s < 3; s++) src_tick[s] <= (per[s] > 0) && (cyc % per[s] == 0);
    end

    // cycle-by-cycle output comparison (R4, R5, R7, R10)
    always @(negedge clk) if (rst_n && !finished) begin
        checks++;
        if (ck_out !== m_outs()) begin
            errors++;
            $display("FAIL R7/R4 cycle %0d: ck_out actual=%h expected=%h", cyc, ck_out, m_outs());
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk); rd_addr = a; #1;
        chk(req, rd_data, exp);
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int tg;
        logic prev;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        chk("R1 outputs low", 32'(ck_out), 32'h0);
        rd("R1 select fields off", SEL0, 32'hFFFFFF00);
        rd("R1 spilled fields off", SEL1, 32'h0000000F);
        rd("R1 divider zero", 12'h200, 32'h0);
        rd("R1 status clear", ST1, 32'h0);
        // R2/R4/R5: output 0 from source 1, divider 2
        wr(12'h200, 32'd2);
        wr(SEL0, 32'hFFFFFD00);
        idle(60);
        rd("R2 field stored", SEL0, 32'hFFFFFD00);
        rd("R8 running from source 1", ST1, 32'h10);
        rd("R8 not running from source 0", ST0, 32'h0);
        // R2: code 3 through the select register is rejected
        wr(SEL0, 32'hFFFFFFFF);
        idle(5);
        rd("R2 code 3 ignored", SEL0, 32'hFFFFFD00);
        rd("R2 still running", ST1, 32'h10);
        // R6: output 13 field spills into the second register
        wr(12'h334, 32'd0);
        wr(SEL1, 32'h0000000B);
        idle(30);
        rd("R6 spilled field", SEL1, 32'h0000000B);
        rd("R6/R8 output 13 running from source 2", ST2, 32'h00020000);
        // R4: divide-by-2 of an every-cycle source toggles every 2 cycles
        wr(12'h334, 32'd1);
        idle(6);
        tg = 0; prev = ck_out[13];
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (ck_out[13] != prev) tg++;
            prev = ck_out[13];
        end
        chk("R4 toggle count", 32'(tg), 32'd20);
        // R10: divider rewrite while running
        wr(12'h334, 32'd6);
        idle(40);
        wr(12'h334, 32'd0);
        idle(20);
        // R5/R7: switch output 0 to source 0 with its own divider
        wr(12'h100, 32'd1);
        @(negedge clk);
        while (ck_out[0] !== 1'b1) @(negedge clk);
        wr(SEL0, 32'hFFFFFC00);
        idle(60);
        rd("R5 now running from source 0", ST0, 32'h10);
        rd("R5 no longer from source 1", ST1, 32'h0);
        // R9: status writes ignored, off register reads zero
        wr(ST2, 32'h0);
        rd("R9 status write ignored", ST2, 32'h00020000);
        rd("R3 off register reads zero", OFFA, 32'h0);
        // R3: stop output 0
        wr(OFFA, 32'h1);
        rd("R3 field off", SEL0, 32'hFFFFFF00);
        idle(30);
        chk("R3 output low", 32'(ck_out[0]), 32'h0);
        rd("R3/R8 status cleared", ST0, 32'h0);
        // R7: restart output 0 on source 2 with a different strobe pattern
        per[0] = 4;
        wr(12'h300, 32'd3);
        wr(SEL0, 32'hFFFFFE00);
        idle(80);
        rd("R7 restarted from source 2", ST2, 32'h00020010);
        finish_run();
    end
endmodule